// File: doc/BRIEF.md
# Bit-Field Insert and Extract Unit

This unit is the bit-field datapath of a 32-bit load/store core. Its main operation places a field into a word: it takes the low-order bits of a source operand and writes them into a destination operand at a chosen bit position. Every destination bit outside that window keeps its value. The same unit also pulls a field out of a word, and it widens a signed byte or a signed halfword to 32 bits.

The unit is fully combinational, and the result follows the inputs with no clock. The field is given as a start position and a length. The caller must keep the field inside the 32-bit word. If the field crosses the top of the word or has zero length, the unit raises an error flag and returns a defined fallback value. Several inserts can be chained, feeding each result back as the next destination, to pack multi-field words such as 16-bit colour pixels.

Top module: `bitfield_unit`

## Requirements
- R1: With `opSel` = 0 (insert), bits `lsbPos` through `lsbPos+fieldLen-1` of `result` equal bits 0 through `fieldLen-1` of `srcIn`.
- R2: With `opSel` = 0 and a valid field, every `result` bit outside the window equals the same bit of `dstIn`.
- R3: An insert at position 3 with length 9 yields `(dstIn & 32'hFFFFF007) | ((srcIn & 32'h1FF) << 3)`.
- R4: An insert with `srcIn` = 0 clears exactly the window bits of `dstIn` and keeps the rest.
- R5: With `opSel` = 1 (extract), `result` is `srcIn` bits `lsbPos` through `lsbPos+fieldLen-1`, right-aligned, with all higher bits zero.
- R6: With `opSel` = 2, `result` is `srcIn[7:0]` sign-extended to 32 bits.
- R7: With `opSel` = 3, `result` is `srcIn[15:0]` sign-extended to 32 bits.
- R8: `fieldLen` holds the length directly, with valid values 1 to 32. Length 32 at position 0 gives `result` = `srcIn` for both insert and extract.
- R9: `fieldErr` is 1 exactly when `opSel` is 0 or 1 and either `fieldLen` = 0 or `lsbPos+fieldLen` > 32. While it is 1, an insert returns `dstIn` and an extract returns 0. `fieldErr` is always 0 for `opSel` 2 and 3.
- R10: Chained inserts compose. Placing 5-, 6- and 5-bit values at positions 0, 5 and 11 builds the packed 16-bit colour word.
- R11: `result` and `fieldErr` respond to an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dstIn | input | 32 | Destination word for an insert |
| srcIn | input | 32 | Field source for insert, extract and sign-extend |
| lsbPos | input | 5 | Bit position of the field's lowest bit |
| fieldLen | input | 6 | Field length, 1 to 32 |
| opSel | input | 2 | 0 insert, 1 extract, 2 sign-extend byte, 3 sign-extend halfword |
| result | output | 32 | Operation result |
| fieldErr | output | 1 | Field lies outside the word or has zero length |

## Verification
Inserts are run with all-ones and all-zeros destinations against alternating-bit sources. This shows whether a wrong bit leaked in from the source or a kept bit was lost. Single-bit fields at both ends of the word and full-word fields find off-by-one errors in the mask edges. Many position/length pairs are compared against a bit-by-bit model, and fields that just fit are tried next to fields that overrun by one to locate the error boundary. Sign-extend inputs with the sign bit set and clear, plus garbage in the upper bits, confirm that only the low byte or halfword is used.

// File: rtl/bitfield_pkg.sv
package bitfield_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned POS_W  = $clog2(WORD_W);
  localparam int unsigned LEN_W  = POS_W + 1;
  localparam int unsigned SUM_W  = LEN_W + 1;

  typedef enum logic [1:0] {
    OP_INSERT  = 2'd0,
    OP_EXTRACT = 2'd1,
    OP_SEXT_B  = 2'd2,
    OP_SEXT_H  = 2'd3
  } bfOp_e;

  typedef struct packed {
    logic selInsert;
    logic selExtract;
    logic selSextB;
    logic selSextH;
    logic fieldOk;
  } bfStrobe_t;
endpackage

// File: rtl/bitfield_ctrl.sv
module bitfield_ctrl
  import bitfield_pkg::*;
#(
  parameter int unsigned WIDTH = WORD_W,
  localparam int unsigned PW = $clog2(WIDTH),
  localparam int unsigned LW = PW + 1,
  localparam int unsigned SW = LW + 1
) (
  input  logic [1:0]    opSel,
  input  logic [PW-1:0] lsbPos,
  input  logic [LW-1:0] fieldLen,
  output bfStrobe_t     strobes,
  output logic          fieldErr
);
  bfOp_e opCode;
  logic [SW-1:0] fieldEnd;
  logic rangeBad;

  assign opCode   = bfOp_e'(opSel);
  assign fieldEnd = SW'(lsbPos) + SW'(fieldLen);
  assign rangeBad = (fieldLen == '0) || (fieldEnd > SW'(WIDTH));

  always_comb begin
    strobes = '0;
    unique case (opCode)
      OP_INSERT:  strobes.selInsert  = 1'b1;
      OP_EXTRACT: strobes.selExtract = 1'b1;
      OP_SEXT_B:  strobes.selSextB   = 1'b1;
      OP_SEXT_H:  strobes.selSextH   = 1'b1;
      default:    strobes = '0;
    endcase
    strobes.fieldOk = !rangeBad;
  end

  assign fieldErr = (strobes.selInsert || strobes.selExtract) && rangeBad;

  // Guards R9: exactly one operation strobe is active at a time.
  always_comb begin
    a_r9_one_strobe: assert ($onehot0({strobes.selInsert, strobes.selExtract,
                                       strobes.selSextB, strobes.selSextH}));
  end
endmodule

// File: rtl/bitfield_dp.sv
module bitfield_dp
  import bitfield_pkg::*;
#(
  parameter int unsigned WIDTH = WORD_W,
  localparam int unsigned PW = $clog2(WIDTH),
  localparam int unsigned LW = PW + 1
) (
  input  bfStrobe_t        strobes,
  input  logic [WIDTH-1:0] dstIn,
  input  logic [WIDTH-1:0] srcIn,
  input  logic [PW-1:0]    lsbPos,
  input  logic [LW-1:0]    fieldLen,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] lenMask;
  logic [WIDTH-1:0] placedMask;
  logic [WIDTH-1:0] insertVal;
  logic [WIDTH-1:0] extractVal;
  logic [WIDTH-1:0] sextByte;
  logic [WIDTH-1:0] sextHalf;

  // Thermometer mask: bit i set when i lies below the field length.
  for (genvar i = 0; i < WIDTH; i++) begin : g_lenMask
    assign lenMask[i] = (LW'(i) < fieldLen);
  end

  assign placedMask = lenMask << lsbPos;
  assign insertVal  = (dstIn & ~placedMask) | ((srcIn & lenMask) << lsbPos);
  assign extractVal = (srcIn >> lsbPos) & lenMask;
  assign sextByte   = {{(WIDTH-8){srcIn[7]}}, srcIn[7:0]};
  assign sextHalf   = {{(WIDTH-16){srcIn[15]}}, srcIn[15:0]};

  always_comb begin
    result = '0;
    if (strobes.selInsert)       result = strobes.fieldOk ? insertVal : dstIn;
    else if (strobes.selExtract) result = strobes.fieldOk ? extractVal : '0;
    else if (strobes.selSextB)   result = sextByte;
    else if (strobes.selSextH)   result = sextHalf;
  end

  always_comb begin
    if (strobes.selInsert && strobes.fieldOk)
      a_r2_outside_kept: assert (((result ^ dstIn) & ~placedMask) == '0);
    if (strobes.selExtract && strobes.fieldOk && fieldLen < LW'(WIDTH))
      a_r5_upper_zero: assert ((result >> fieldLen) == '0);
    if (strobes.selSextB)
      a_r6_byte_sign: assert (result[WIDTH-1:8] == {(WIDTH-8){result[7]}});
    if (strobes.selSextH)
      a_r7_half_sign: assert (result[WIDTH-1:16] == {(WIDTH-16){result[15]}});
    if (strobes.selExtract && !strobes.fieldOk)
      a_r9_bad_extract_zero: assert (result == '0);
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bitfield_pkg::*;
(
  input  logic [31:0] dstIn,
  input  logic [31:0] srcIn,
  input  logic [4:0]  lsbPos,
  input  logic [5:0]  fieldLen,
  input  logic [1:0]  opSel,
  output logic [31:0] result,
  output logic        fieldErr
);
  bfStrobe_t strobes;

  bitfield_ctrl #(.WIDTH(WORD_W)) i_ctrl (
    .opSel    (opSel),
    .lsbPos   (lsbPos),
    .fieldLen (fieldLen),
    .strobes  (strobes),
    .fieldErr (fieldErr)
  );

  bitfield_dp #(.WIDTH(WORD_W)) i_dp (
    .strobes  (strobes),
    .dstIn    (dstIn),
    .srcIn    (srcIn),
    .lsbPos   (lsbPos),
    .fieldLen (fieldLen),
    .result   (result)
  );
endmodule

// File: tb/test_bitfield_unit.sv
module test_bitfield_unit;
  logic clk = 1'b0;
  logic [31:0] dstIn, srcIn;
  logic [4:0]  lsbPos;
  logic [5:0]  fieldLen;
  logic [1:0]  opSel;
  logic [31:0] result;
  logic        fieldErr;
  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bitfield_unit i_bitfield_unit (
    .dstIn(dstIn), .srcIn(srcIn), .lsbPos(lsbPos), .fieldLen(fieldLen),
    .opSel(opSel), .result(result), .fieldErr(fieldErr)
  );

  function automatic logic [31:0] modelInsert(logic [31:0] d, logic [31:0] s, int p, int n);
    logic [31:0] r = d;
    for (int i = 0; i < 32; i++)
      if (i >= p && i < p + n) r[i] = s[i-p];
    return r;
  endfunction

  function automatic logic [31:0] modelExtract(logic [31:0] s, int p, int n);
    logic [31:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = s[p+i];
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] op, logic [31:0] d, logic [31:0] s, int p, int n);
    @(negedge clk);
    opSel = op; dstIn = d; srcIn = s; lsbPos = 5'(p); fieldLen = 6'(n);
    #1;
  endtask

  task automatic tIdle();
    apply(2'd0, 32'h0, 32'h0, 0, 1);
    check("R1 idle result", result, 32'h0);
    check("R9 idle err", {31'b0, fieldErr}, 32'h0);
  endtask

  task automatic tInsertPatterns();
    apply(2'd0, 32'hFFFF_FFFF, 32'h5555_5555, 4, 8);
    check("R1 ins ones/alt", result, modelInsert(32'hFFFF_FFFF, 32'h5555_5555, 4, 8));
    apply(2'd0, 32'h0, 32'hAAAA_AAAA, 20, 7);
    check("R2 ins zeros/alt", result, modelInsert(32'h0, 32'hAAAA_AAAA, 20, 7));
    apply(2'd0, 32'h1234_5678, 32'hFFFF_FFFF, 31, 1);
    check("R1 ins top bit", result, 32'h9234_5678);
    apply(2'd0, 32'hFFFF_FFFF, 32'h0, 0, 1);
    check("R1 ins bottom bit", result, 32'hFFFF_FFFE);
    for (int p = 0; p < 32; p += 3)
      for (int n = 1; n + p <= 32; n += 5) begin
        apply(2'd0, 32'hC3A5_0F96 ^ (p * 32'h0101_0101), 32'h6B2D_E847 + n, p, n);
        check("R2 ins sweep", result,
              modelInsert(32'hC3A5_0F96 ^ (p * 32'h0101_0101), 32'h6B2D_E847 + n, p, n));
      end
  endtask

  task automatic tWorkedExample();
    apply(2'd0, 32'hDEAD_BEEF, 32'h1357_9BDF, 3, 9);
    check("R3 pos3 len9", result,
          (32'hDEAD_BEEF & 32'hFFFF_F007) | ((32'h1357_9BDF & 32'h1FF) << 3));
  endtask

  task automatic tZeroSource();
    apply(2'd0, 32'hFFFF_FFFF, 32'h0, 0, 4);
    check("R4 clear low nibble", result, 32'hFFFF_FFF0);
    apply(2'd0, 32'h8765_4321, 32'h0, 12, 8);
    check("R4 clear mid", result, 32'h8760_0321);
  endtask

  task automatic tExtract();
    apply(2'd1, 32'hFFFF_FFFF, 32'hABCD_1234, 8, 12);
    check("R5 extract mid", result, 32'h0000_0D12);
    apply(2'd1, 32'h0, 32'h8000_0000, 31, 1);
    check("R5 extract top", result, 32'h1);
    for (int p = 1; p < 32; p += 4) begin
      apply(2'd1, 32'h0, 32'h9E37_79B9, p, 32 - p);
      check("R5 extract sweep", result, modelExtract(32'h9E37_79B9, p, 32 - p));
    end
  endtask

  task automatic tSext();
    apply(2'd2, 32'h0, 32'h1234_5680, 0, 0);
    check("R6 byte neg", result, 32'hFFFF_FF80);
    apply(2'd2, 32'h0, 32'hFFFF_FF7F, 0, 0);
    check("R6 byte pos", result, 32'h0000_007F);
    check("R9 sext no err", {31'b0, fieldErr}, 32'h0);
    apply(2'd3, 32'h0, 32'h0000_8001, 31, 32);
    check("R7 half neg", result, 32'hFFFF_8001);
    check("R9 sext no err overrun", {31'b0, fieldErr}, 32'h0);
    apply(2'd3, 32'h0, 32'hFFFF_7FFE, 0, 1);
    check("R7 half pos", result, 32'h0000_7FFE);
  endtask

  task automatic tFullWord();
    apply(2'd0, 32'h1111_1111, 32'hCAFE_F00D, 0, 32);
    check("R8 ins full", result, 32'hCAFE_F00D);
    check("R8 ins full no err", {31'b0, fieldErr}, 32'h0);
    apply(2'd1, 32'h0, 32'hCAFE_F00D, 0, 32);
    check("R8 ext full", result, 32'hCAFE_F00D);
  endtask

  task automatic tErrors();
    apply(2'd0, 32'h2468_ACE0, 32'hFFFF_FFFF, 24, 8);
    check("R9 fits err", {31'b0, fieldErr}, 32'h0);
    apply(2'd0, 32'h2468_ACE0, 32'hFFFF_FFFF, 24, 9);
    check("R9 overrun err", {31'b0, fieldErr}, 32'h1);
    check("R9 overrun ins passthru", result, 32'h2468_ACE0);
    apply(2'd1, 32'h0, 32'hFFFF_FFFF, 1, 32);
    check("R9 ext overrun err", {31'b0, fieldErr}, 32'h1);
    check("R9 ext overrun zero", result, 32'h0);
    apply(2'd0, 32'h0F0F_0F0F, 32'hFFFF_FFFF, 5, 0);
    check("R9 zero len err", {31'b0, fieldErr}, 32'h1);
    check("R9 zero len passthru", result, 32'h0F0F_0F0F);
  endtask

  task automatic tRgb565();
    logic [31:0] w;
    logic [7:0] r8 = 8'hA8, g8 = 8'h6C, b8 = 8'hD0;
    apply(2'd0, 32'(r8 >> 3), 32'(g8 >> 2), 5, 6);
    w = result;
    apply(2'd0, w, 32'(b8 >> 3), 11, 5);
    check("R10 rgb565", result, {16'h0, b8[7:3], g8[7:2], r8[7:3]});
  endtask

  task automatic tNoClock();
    @(posedge clk);
    #0.5;
    opSel = 2'd0; dstIn = 32'h0; srcIn = 32'hF; lsbPos = 5'd4; fieldLen = 6'd4;
    #0.5;
    check("R11 mid-cycle ins", result, 32'h0000_00F0);
    lsbPos = 5'd30;
    #0.5;
    check("R11 mid-cycle err", {31'b0, fieldErr}, 32'h1);
  endtask

  initial begin
    tIdle();
    tInsertPatterns();
    tWorkedExample();
    tZeroSource();
    tExtract();
    tSext();
    tFullWord();
    tErrors();
    tRgb565();
    tNoClock();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule